// File: doc/BRIEF.md
# IMDCT and Windowing Engine

This block turns one subband's worth of frequency-domain samples into a windowed time-domain frame for an audio decoder. A start strobe loads 18 spectral samples and a two-bit block-type code. The engine then works through the 36 output positions one at a time. For each position it forms the inverse modified cosine sum in a wide accumulator, rounds that sum to sample width, scales it by the window coefficient for that position, and offers the result on a valid/ready stream. Combining the frame with the previous one (overlap-add) is done outside this block.

The datapath has one signed multiplier and one adder. Multiplexers feed them the operands for each phase: spectral sample times cosine while accumulating, rounded sum times window coefficient while windowing, and rounding constants during the two narrowing steps. Cosine and window values are read from a single quarter-wave table of 37 entries. Sign and index folding turn that one table into both the 36-point kernel and the 12-point kernel and into every window shape. Long blocks use one 36-point transform. Short blocks run three interleaved 12-point transforms and place them at staggered offsets inside the 36-sample frame.

Top module: `imdct_win_engine`

## Requirements
- R1: While reset is held, and after it is released with no start strobe, `out_valid` and `done` stay 0.
- R2: Samples and coefficients are signed fixed point with 23 fraction bits (24-bit Q1.23). With `blk_type` 0 (normal), output n (0..35) is W(n)·S(n) within 16 LSB. Here S(n) is the sum over k = 0..17 of x[k]·cos(π(2n+19)(2k+1)/72), and W(n) = sin(π(2n+1)/72). Sample x[k] sits at bits [24k+23:24k] of `spec_in`.
- R3: With `blk_type` 1 (start), the window is sin(π(2n+1)/72) for n < 18, 1.0 for 18..23, sin(π(2(n−18)+1)/24) for 24..29, and 0 for 30..35.
- R4: With `blk_type` 3 (stop), the window is 0 for n < 6, sin(π(2(n−6)+1)/24) for 6..11, 1.0 for 12..17, and sin(π(2n+1)/72) for 18..35.
- R5: With `blk_type` 2 (short), sub-transform w (0..2) uses inputs x[3k+w], k = 0..5. It gives v_w(j) = Σ x[3k+w]·cos(π(2j+7)(2k+1)/24) for j = 0..11. Each value is windowed by sin(π(2j+1)/24) and added into output 6+6w+j, with overlaps summed. Outputs 0..5 and 30..35 are exactly 0.
- R6: The block type is taken from `blk_type` in the cycle the start is accepted. Changes on `blk_type` or `spec_in` after that have no effect on the running block.
- R7: The transform sum is saturated to [−1, 1−2⁻²³] before windowing. Each output is saturated to [−2²³, 2²³−1].
- R8: The 36 outputs appear in index order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R9: `done` is a one-cycle pulse in the cycle after the 36th output is accepted.
- R10: A start strobe is ignored from the accepted start until the cycle after the 36th output is accepted. This includes a start that coincides with that final acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block when idle |
| blk_type | input | 2 | 0 normal, 1 start, 2 short, 3 stop |
| spec_in | input | 432 | 18 packed Q1.23 spectral samples, x[0] in the low bits |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_data | output | 24 | Windowed Q1.23 time sample |
| done | output | 1 | Pulse after the last sample is accepted |

## Verification
Two events can land on the same clock edge: a new start strobe, and an output handshake or stall on the current block. The bench raises `start` with fresh data and a different block type while a frame is mid-stream. It also raises `start` exactly in the cycle the 36th sample is accepted. The first case is judged by every remaining output still matching a double-precision model of the original block. The second is judged by `out_valid` staying low afterwards. Back-pressure patterns are mixed in, so that starts also arrive while an output is being held.

// File: rtl/imdct_win_engine.sv
module imdct_win_engine #(
  parameter int DW    = 24,
  parameter int AW    = 48,
  parameter int GUARD = 5
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           blk_type,
  input  logic [18*DW-1:0]     spec_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  output logic                 done
);
  localparam int NSPEC  = 18;
  localparam int NOUT   = 36;
  localparam int QTR    = 37;
  localparam int FB     = DW - 1;
  localparam int PW     = 2 * DW;
  localparam int SUM_SH = FB - GUARD;
  localparam int OUT_SH = FB;
  localparam logic [1:0] BT_NORM = 2'd0, BT_START = 2'd1, BT_SHORT = 2'd2, BT_STOP = 2'd3;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {FB{1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {FB{1'b0}}};
  localparam logic signed [AW-1:0] RND_S = AW'(1) <<< (SUM_SH - 1);
  localparam logic signed [AW-1:0] RND_O = AW'(1) <<< (OUT_SH - 1);
  localparam logic [5:0] LAST_O = 6'(NOUT - 1);

  function automatic logic [QTR*DW-1:0] build_rom();
    logic [QTR*DW-1:0] r;
    real v;
    int q;
    r = '0;
    for (int j = 0; j < QTR; j++) begin
      v = $cos(3.14159265358979323846 * j / 72.0) * (2.0 ** FB);
      q = $rtoi(v + 0.5);
      if (q > (2 ** FB) - 1) q = (2 ** FB) - 1;
      r[j*DW +: DW] = q[DW-1:0];
    end
    return r;
  endfunction

  localparam logic [QTR*DW-1:0] QROM = build_rom();

  function automatic logic signed [DW-1:0] rom(input int j);
    return QROM[j*DW +: DW];
  endfunction

  function automatic logic signed [DW-1:0] qcos(input int m);
    int a;
    a = m % 144;
    if (a < 0) a = a + 144;
    if (a <= 36)       return rom(a);
    else if (a <= 72)  return -rom(72 - a);
    else if (a <= 108) return -rom(a - 72);
    else               return rom(144 - a);
  endfunction

  function automatic logic signed [DW-1:0] qsin(input int m);
    return rom(m > 36 ? m - 36 : 36 - m);
  endfunction

  function automatic logic signed [DW-1:0] win_coef(input logic [1:0] bt, input int o, input int jl);
    case (bt)
      BT_SHORT: return (jl >= 0 && jl < 12) ? qsin(6*jl + 3) : '0;
      BT_START: begin
        if (o < 18)      return qsin(2*o + 1);
        else if (o < 24) return rom(0);
        else if (o < 30) return qsin(6*o - 105);
        else             return '0;
      end
      BT_STOP: begin
        if (o < 6)       return '0;
        else if (o < 12) return qsin(6*o - 33);
        else if (o < 18) return rom(0);
        else             return qsin(2*o + 1);
      end
      default: return qsin(2*o + 1);
    endcase
  endfunction

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [AW-1:0] v, input int sh);
    logic signed [AW-1:0] s;
    s = v >>> sh;
    if (s > AW'(MAXV))      return MAXV;
    else if (s < AW'(MINV)) return MINV;
    else                    return s[DW-1:0];
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_SEG, S_MAC, S_RND1, S_WIN, S_RND2, S_OUT} st_t;

  st_t st;
  logic signed [DW-1:0] spec [NSPEC];
  logic [1:0] bt_r;
  logic [5:0] oi;
  logic [1:0] wi;
  logic [4:0] ki;
  logic signed [AW-1:0] acc, oacc;

  int o_n, w_n, k_n, jl, x_n, mc;
  logic covers, is_short;
  logic [4:0] k_last;
  logic signed [DW-1:0] sum24, mul_a, mul_b;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext, add_a, add_b, add_y;

  assign is_short = (bt_r == BT_SHORT);
  assign k_last   = is_short ? 5'd5 : 5'd17;
  assign sum24    = sat_dw(acc, SUM_SH);

  always_comb begin
    o_n = int'(oi);
    w_n = int'(wi);
    k_n = int'(ki);
    jl  = o_n - 6 - 6*w_n;
    covers = !is_short || (jl >= 0 && jl < 12);
    x_n = is_short ? 3*k_n + w_n : k_n;
    if (x_n >= NSPEC) x_n = 0;
    if (is_short) mc = 3 * (2*(jl < 0 ? 0 : jl) + 7) * (2*k_n + 1);
    else          mc = (2*o_n + 19) * (2*k_n + 1);
  end

  assign mul_a    = (st == S_WIN) ? sum24 : spec[x_n];
  assign mul_b    = (st == S_WIN) ? win_coef(bt_r, o_n, jl) : qcos(mc);
  assign prod     = PW'(mul_a) * PW'(mul_b);
  assign prod_ext = AW'(prod);

  always_comb begin
    add_a = (st == S_WIN || st == S_RND2) ? oacc : acc;
    case (st)
      S_MAC:   add_b = prod_ext >>> GUARD;
      S_RND1:  add_b = RND_S;
      S_WIN:   add_b = prod_ext;
      S_RND2:  add_b = RND_O;
      default: add_b = '0;
    endcase
  end
  assign add_y = add_a + add_b;

  assign out_valid = (st == S_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < NSPEC; i++) spec[i] <= '0;
      bt_r <= BT_NORM;
      oi <= '0;
      wi <= '0;
      ki <= '0;
      acc <= '0;
      oacc <= '0;
      out_data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < NSPEC; i++) spec[i] <= spec_in[i*DW +: DW];
          bt_r <= blk_type;
          oi <= '0;
          wi <= '0;
          oacc <= '0;
          st <= S_SEG;
        end
        S_SEG: begin
          if (covers) begin
            acc <= '0;
            ki <= '0;
            st <= S_MAC;
          end else if (wi == 2'd2) st <= S_RND2;
          else wi <= wi + 2'd1;
        end
        S_MAC: begin
          acc <= add_y;
          if (ki == k_last) st <= S_RND1;
          else ki <= ki + 5'd1;
        end
        S_RND1: begin
          acc <= add_y;
          st <= S_WIN;
        end
        S_WIN: begin
          oacc <= add_y;
          if (!is_short || wi == 2'd2) st <= S_RND2;
          else begin
            wi <= wi + 2'd1;
            st <= S_SEG;
          end
        end
        S_RND2: begin
          out_data <= sat_dw(add_y, OUT_SH);
          st <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          if (oi == LAST_O) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            oi <= oi + 6'd1;
            wi <= '0;
            oacc <= '0;
            st <= S_SEG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && oi != LAST_O |=> !out_valid && oi == $past(oi) + 6'd1);

  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && oi == LAST_O));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  short_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_short && (oi < 6'd6 || oi >= 6'd30) |-> out_data == '0);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && st != S_IDLE |=> $stable(bt_r) && $stable(spec[0]));
endmodule

// File: tb/imdct_win_engine_test.sv
`timescale 1ns/1ps
module imdct_win_engine_test;
  localparam int TOL = 16;
  localparam real SC = 8388608.0;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n, start, out_ready;
  logic [1:0] blk_type;
  logic [18*24-1:0] spec_in;
  logic out_valid, done;
  logic signed [23:0] out_data;

  int total = 0, bad = 0;
  int qx [18];
  int exi [36];
  int unsigned seed = 32'h1234_5678;

  imdct_win_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_type(blk_type),
    .spec_in(spec_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  function automatic real rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return (real'(seed) / 4294967296.0) * 2.0 - 1.0;
  endfunction

  function automatic real clampq(input real v);
    if (v > 1.0 - 1.0/SC) return 1.0 - 1.0/SC;
    if (v < -1.0) return -1.0;
    return v;
  endfunction

  function automatic real winref(input int bt, input int o);
    case (bt)
      1: begin
        if (o < 18) return $sin(PI/36.0*(o+0.5));
        if (o < 24) return 1.0;
        if (o < 30) return $sin(PI/12.0*(o-18+0.5));
        return 0.0;
      end
      3: begin
        if (o < 6)  return 0.0;
        if (o < 12) return $sin(PI/12.0*(o-6+0.5));
        if (o < 18) return 1.0;
        return $sin(PI/36.0*(o+0.5));
      end
      default: return $sin(PI/36.0*(o+0.5));
    endcase
  endfunction

  task automatic build_ref(input int bt);
    for (int o = 0; o < 36; o++) begin
      real tot, s, e;
      int ei;
      tot = 0.0;
      if (bt == 2) begin
        for (int w = 0; w < 3; w++) begin
          int j;
          j = o - 6 - 6*w;
          if (j >= 0 && j < 12) begin
            s = 0.0;
            for (int k = 0; k < 6; k++)
              s += (qx[3*k+w] / SC) * $cos(PI/24.0*(2*j+7)*(2*k+1));
            tot += clampq(s) * $sin(PI/12.0*(j+0.5));
          end
        end
      end else begin
        s = 0.0;
        for (int k = 0; k < 18; k++)
          s += (qx[k] / SC) * $cos(PI/72.0*(2*o+19)*(2*k+1));
        tot = clampq(s) * winref(bt, o);
      end
      e = clampq(tot) * SC;
      ei = (e >= 0.0) ? $rtoi(e + 0.5) : -$rtoi(-e + 0.5);
      if (ei > 8388607) ei = 8388607;
      exi[o] = ei;
    end
  endtask

  task automatic fill(input int kind, input real amp, input int pos);
    for (int k = 0; k < 18; k++) begin
      real v;
      case (kind)
        0: v = (k == pos) ? amp : 0.0;
        1: v = amp * rnd();
        2: v = amp;
        default: v = (k % 2 == 0) ? amp : -amp;
      endcase
      qx[k] = $rtoi(v * SC);
    end
  endtask

  task automatic run_block(input int bt, input string req, input int rmode, input int poke);
    int n, cyc, d;
    bit prev_stall, rdy, poked;
    logic signed [23:0] prev_d;
    for (int k = 0; k < 18; k++) spec_in[k*24 +: 24] = qx[k][23:0];
    blk_type = bt[1:0];
    build_ref(bt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; cyc = 0; prev_stall = 1'b0; poked = 1'b0; prev_d = '0;
    while (n < 36) begin
      @(negedge clk);
      start = 1'b0;
      rdy = (rmode == 0) ? 1'b1 : (((cyc * 7) % 5) < 3);
      cyc++;
      out_ready = rdy;
      if (prev_stall)
        check(out_valid === 1'b1 && out_data === prev_d, "R8", "held sample under stall",
              int'($signed(out_data)), int'(prev_d));
      prev_stall = out_valid && !rdy;
      prev_d = out_data;
      if (poke == 1 && n == 5 && !poked) begin
        start = 1'b1;
        spec_in = ~spec_in;
        blk_type = ~blk_type;
        poked = 1'b1;
      end
      if (out_valid && rdy) begin
        d = int'($signed(out_data)) - exi[n];
        if (d < 0) d = -d;
        check(d <= TOL, req, $sformatf("sample %0d type %0d", n, bt), int'($signed(out_data)), exi[n]);
        n++;
        if (n == 36 && poke == 2) start = 1'b1;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R9", "done after last accept", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && out_valid === 1'b0, "R9", "done single pulse", int'(done), 0);
    if (poke == 2) begin
      repeat (6) @(negedge clk);
      check(out_valid === 1'b0, "R10", "start at final accept ignored", int'(out_valid), 0);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0; blk_type = 2'd0; spec_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R1", "state in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R1", "idle without start", int'(out_valid), 0);

    fill(0, 0.5, 3);   run_block(0, "R2", 0, 0);
    fill(1, 0.1, 0);   run_block(0, "R2", 1, 0);
    fill(3, 0.05, 0);  run_block(0, "R2", 0, 0);
    fill(1, 0.1, 0);   run_block(1, "R3", 0, 0);
    fill(1, 0.1, 0);   run_block(3, "R4", 1, 0);
    fill(1, 0.2, 0);   run_block(2, "R5", 0, 0);
    fill(0, 0.7, 7);   run_block(2, "R5", 1, 0);
    fill(3, 0.15, 0);  run_block(2, "R5", 0, 0);
    fill(2, 0.9, 0);   run_block(0, "R7", 0, 0);
    fill(2, -0.95, 0); run_block(2, "R7", 1, 0);
    fill(1, 0.1, 0);   run_block(1, "R6", 1, 1);
    fill(1, 0.1, 0);   run_block(2, "R10", 0, 1);
    fill(1, 0.1, 0);   run_block(3, "R10", 1, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule